// File: doc/BRIEF.md
# Capacitive Touch Detection Filter

This block sits behind a capacitive acquisition engine. It receives a stream of 14-bit unsigned measurement results, each marked by a valid strobe, and produces a debounced touch flag. It keeps a reference level that follows slow environmental change. The reference drifts down quickly when the signal falls below it and up slowly when the signal rises above it. Every accepted sample yields a signed delta against that reference. A touch is a positive delta that reaches a selectable threshold. Release needs the delta to fall below a lower level, set by percentage hysteresis.

A state change happens only after several agreeing samples in a row. A free-running 1 ms tick paces the drift steps and the maximum-detection timer. When a detection lasts past the selected limit, the next sample recalibrates the reference. This keeps a stuck touch from holding the flag forever. All outputs are registered and change only in the cycle after a valid sample.

Top module: `touch_filter`

## Requirements
- R1: During reset, detect, ref_level and delta are 0. The first valid sample after reset loads ref_level with that sample, clears detect and sets delta to 0, all in the cycle after the sample.
- R2: For every other valid sample, delta becomes the sample minus ref_level as a 15-bit two's-complement value, one cycle after the sample. The ref_level used is the one held before that sample.
- R3: The touch threshold is 6 counts when thr_sel is 0 and 12 counts when thr_sel is 1. A sample counts toward a touch when its delta is greater than or equal to the threshold.
- R4: detect changes state only on the 3rd consecutive valid sample that calls for the change. Any valid sample that does not call for the change resets the run to zero.
- R5: While detect is 1, a sample calls for release only when its delta is below the threshold minus floor(17 % of the threshold): below 5 for threshold 6, below 10 for threshold 12.
- R6: While detect is 0, a valid sample with negative delta lowers ref_level by 1 if at least 100 ticks have passed since the last downward step, the last release or the last load. That step restarts the downward count.
- R7: While detect is 0, a valid sample with positive delta raises ref_level by 1 if at least 1000 ticks have passed since the last upward step, the last release or the last load. That step restarts the upward count.
- R8: While detect is 1, ref_level does not drift, and both drift counts are held at zero.
- R9: recal_sel 00 selects a 10000-tick detection limit, 01 selects 60000 ticks, and 1x disables the limit. Once detect has been 1 for at least the limit, the next valid sample recalibrates: ref_level takes the sample, detect clears and delta reads 0.
- R10: A cycle with smp_valid low changes none of detect, ref_level and delta, whatever smp_data, tick_ms and the option inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Marks smp_data as a new acquisition result |
| smp_data | input | 14 | Unsigned acquisition result |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| thr_sel | input | 1 | Threshold option: 0 for 6 counts, 1 for 12 counts |
| recal_sel | input | 2 | Detection limit: 00 10 s, 01 60 s, 1x none |
| detect | output | 1 | Debounced touch flag |
| ref_level | output | 14 | Current reference level |
| delta | output | 15 | Signed delta of the last judged sample |

## Verification
Each of the three outputs is registered once, so it is due exactly one clock after the edge that takes a valid sample. The bench drives every input on the falling edge and steps a reference model on the rising edge. It compares all three outputs at the next falling edge. In the drift and limit phases, tick_ms is held high on every cycle, so each cycle is one millisecond. This lets the 100, 1000, 10000 and 60000 tick boundaries land on known cycle counts, with samples placed on either side of them.

// File: rtl/touch_filter_pkg.sv
package touch_filter_pkg;

  // Release level: threshold minus the hysteresis share, rounded down.
  function automatic int rel_level(input int thr, input int pct);
    return thr - (thr * pct) / 100;
  endfunction

  typedef enum logic [1:0] {
    RC_10S   = 2'b00,
    RC_60S   = 2'b01,
    RC_OFF_A = 2'b10,
    RC_OFF_B = 2'b11
  } recal_sel_e;

endpackage

// File: rtl/tf_sat_timer.sv
module tf_sat_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic [$clog2(LIMIT+1)-1:0] cnt,
  output logic full
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && cnt != LIM_V)
      cnt <= cnt + 1'b1;
  end

  assign full = (cnt == LIM_V);
endmodule

// File: rtl/tf_consensus.sv
module tf_consensus #(
  parameter int N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic agree,
  output logic flip
);
  localparam int W = (N > 2) ? $clog2(N) : 1;
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] run_q;

  assign flip = step && agree && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)
      run_q <= '0;
    else if (step) begin
      if (!agree || flip)
        run_q <= '0;
      else
        run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/tf_reference.sv
module tf_reference #(
  parameter int SW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SW-1:0] load_val,
  input  logic          up,
  input  logic          dn,
  output logic [SW-1:0] ref_q
);
  always_ff @(posedge clk) begin
    if (rst)
      ref_q <= '0;
    else if (load)
      ref_q <= load_val;
    else if (dn)
      ref_q <= ref_q - 1'b1;
    else if (up)
      ref_q <= ref_q + 1'b1;
  end
endmodule

// File: rtl/touch_filter.sv
module touch_filter
  import touch_filter_pkg::*;
#(
  parameter int SW           = 14,
  parameter int CONSENSUS_N  = 3,
  parameter int THR_LO       = 6,
  parameter int THR_HI       = 12,
  parameter int HYST_PCT     = 17,
  parameter int DN_PERIOD_MS = 100,
  parameter int UP_PERIOD_MS = 1000,
  parameter int RECAL_A_MS   = 10000,
  parameter int RECAL_B_MS   = 60000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic [SW-1:0]        smp_data,
  input  logic                 tick_ms,
  input  logic                 thr_sel,
  input  logic [1:0]           recal_sel,
  output logic                 detect,
  output logic [SW-1:0]        ref_level,
  output logic signed [SW:0]   delta
);
  localparam int DW  = SW + 1;
  localparam int DNW = $clog2(DN_PERIOD_MS + 1);
  localparam int UPW = $clog2(UP_PERIOD_MS + 1);
  localparam int RCW = $clog2(RECAL_B_MS + 1);
  localparam logic signed [DW-1:0] THR_LO_V = DW'(THR_LO);
  localparam logic signed [DW-1:0] THR_HI_V = DW'(THR_HI);
  localparam logic signed [DW-1:0] REL_LO_V = DW'(rel_level(THR_LO, HYST_PCT));
  localparam logic signed [DW-1:0] REL_HI_V = DW'(rel_level(THR_HI, HYST_PCT));
  localparam logic [RCW-1:0]       RC_A_V   = RCW'(RECAL_A_MS);

  logic                 init_q, det_q;
  logic [SW-1:0]        ref_q;
  logic signed [DW-1:0] diff, thr_v, rel_v;
  logic                 load, judge, want, flip, recal_due;
  logic                 drift_dn, drift_up;
  logic [DNW-1:0]       dn_cnt;
  logic [UPW-1:0]       up_cnt;
  logic [RCW-1:0]       rc_cnt;
  logic                 dn_full, up_full, rc_full, rc_hit;

  // Signed difference of sample and reference
  assign diff  = $signed({1'b0, smp_data}) - $signed({1'b0, ref_q});
  assign thr_v = thr_sel ? THR_HI_V : THR_LO_V;
  assign rel_v = thr_sel ? REL_HI_V : REL_LO_V;

  always_comb begin
    case (recal_sel_e'(recal_sel))
      RC_10S:  rc_hit = (rc_cnt >= RC_A_V);
      RC_60S:  rc_hit = rc_full;
      default: rc_hit = 1'b0;
    endcase
  end

  assign recal_due = det_q && rc_hit;
  assign load      = smp_valid && (!init_q || recal_due);
  assign judge     = smp_valid && !load;
  assign want      = det_q ? (diff < rel_v) : (diff >= thr_v);
  assign drift_dn  = judge && !det_q && diff[DW-1] && dn_full;
  assign drift_up  = judge && !det_q && !diff[DW-1] && (diff != '0) && up_full;

  tf_sat_timer #(.LIMIT(DN_PERIOD_MS)) u_dn_tmr (
    .clk(clk), .rst(rst), .clr(det_q || drift_dn || load), .inc(tick_ms),
    .cnt(dn_cnt), .full(dn_full)
  );

  tf_sat_timer #(.LIMIT(UP_PERIOD_MS)) u_up_tmr (
    .clk(clk), .rst(rst), .clr(det_q || drift_up || load), .inc(tick_ms),
    .cnt(up_cnt), .full(up_full)
  );

  tf_sat_timer #(.LIMIT(RECAL_B_MS)) u_rc_tmr (
    .clk(clk), .rst(rst), .clr(!det_q || load), .inc(tick_ms),
    .cnt(rc_cnt), .full(rc_full)
  );

  tf_consensus #(.N(CONSENSUS_N)) u_cons (
    .clk(clk), .rst(rst), .clr(load), .step(judge), .agree(want), .flip(flip)
  );

  tf_reference #(.SW(SW)) u_ref (
    .clk(clk), .rst(rst), .load(load), .load_val(smp_data),
    .up(drift_up), .dn(drift_dn), .ref_q(ref_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= 1'b0;
      det_q  <= 1'b0;
      delta  <= '0;
    end else if (load) begin
      init_q <= 1'b1;
      det_q  <= 1'b0;
      delta  <= '0;
    end else if (judge) begin
      delta <= diff;
      if (flip)
        det_q <= !det_q;
    end
  end

  assign detect    = det_q;
  assign ref_level = ref_q;
endmodule

// File: rtl/touch_filter_chk.sv
module touch_filter_chk
  import touch_filter_pkg::*;
#(
  parameter int SW       = 14,
  parameter int THR_LO   = 6,
  parameter int THR_HI   = 12,
  parameter int HYST_PCT = 17
) (
  input logic               clk,
  input logic               rst,
  input logic               smp_valid,
  input logic [SW-1:0]      smp_data,
  input logic               thr_sel,
  input logic               detect,
  input logic [SW-1:0]      ref_level,
  input logic signed [SW:0] delta
);
  localparam logic signed [SW:0] T_LO = (SW+1)'(THR_LO);
  localparam logic signed [SW:0] T_HI = (SW+1)'(THR_HI);
  localparam logic signed [SW:0] R_LO = (SW+1)'(rel_level(THR_LO, HYST_PCT));
  localparam logic signed [SW:0] R_HI = (SW+1)'(rel_level(THR_HI, HYST_PCT));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ($stable(detect) && $stable(ref_level) && $stable(delta)));

  p_rise_thr_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(detect) |-> (delta >= ($past(thr_sel) ? T_HI : T_LO)));

  p_rise_on_sample_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(detect) |-> $past(smp_valid));

  p_fall_hyst_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(detect) |-> (delta < ($past(thr_sel) ? R_HI : R_LO)));

  p_drift_step_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !detect) |=>
      ((ref_level == $past(ref_level)) || (ref_level == $past(ref_level) + 1'b1) ||
       (ref_level == $past(ref_level) - 1'b1) || (ref_level == $past(smp_data))));

  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && detect) |=>
      ((ref_level == $past(ref_level)) || (!detect && ref_level == $past(smp_data))));
endmodule

bind touch_filter touch_filter_chk #(
  .SW(SW), .THR_LO(THR_LO), .THR_HI(THR_HI), .HYST_PCT(HYST_PCT)
) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
  .thr_sel(thr_sel), .detect(detect), .ref_level(ref_level), .delta(delta)
);

// File: tb/sim_touch_filter.sv
module sim_touch_filter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               smp_valid = 1'b0;
  logic [13:0]        smp_data = '0;
  logic               tick_ms = 1'b0;
  logic               thr_sel = 1'b0;
  logic [1:0]         recal_sel = 2'b10;
  logic               detect;
  logic [13:0]        ref_level;
  logic signed [14:0] delta;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  // Reference model state
  int m_ref, m_det, m_cnt, m_init, m_dn, m_up, m_rc, m_delta;

  touch_filter u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .tick_ms(tick_ms), .thr_sel(thr_sel), .recal_sel(recal_sel),
    .detect(detect), .ref_level(ref_level), .delta(delta)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int thr_of(input logic ts);
    return ts ? 12 : 6;
  endfunction

  function automatic int rel_of(input logic ts);
    int t = thr_of(ts);
    return t - (t * 17) / 100;
  endfunction

  function automatic int lim_of(input logic [1:0] rs);
    return (rs == 2'b00) ? 10000 : (rs == 2'b01) ? 60000 : -1;
  endfunction

  task automatic model_reset();
    m_ref = 0; m_det = 0; m_cnt = 0; m_init = 0;
    m_dn = 0; m_up = 0; m_rc = 0; m_delta = 0;
  endtask

  // One clock of the requirement-level model, using pre-edge inputs
  task automatic model_step(input logic v, input int s, input logic tk);
    int dn_n, up_n, rc_n, d, lim, want;
    if (m_det != 0) begin
      dn_n = 0; up_n = 0;
      rc_n = (tk && m_rc < 60000) ? m_rc + 1 : m_rc;
    end else begin
      rc_n = 0;
      dn_n = (tk && m_dn < 100)  ? m_dn + 1 : m_dn;
      up_n = (tk && m_up < 1000) ? m_up + 1 : m_up;
    end
    lim = lim_of(recal_sel);
    if (v) begin
      if (m_init == 0 || (m_det != 0 && lim > 0 && m_rc >= lim)) begin
        m_ref = s; m_det = 0; m_cnt = 0; m_init = 1; m_delta = 0;
        dn_n = 0; up_n = 0; rc_n = 0;
      end else begin
        d = s - m_ref;
        m_delta = d;
        want = (m_det != 0) ? (d < rel_of(thr_sel)) : (d >= thr_of(thr_sel));
        if (m_det == 0) begin
          if (d < 0 && m_dn >= 100) begin m_ref = m_ref - 1; dn_n = 0; end
          if (d > 0 && m_up >= 1000) begin m_ref = m_ref + 1; up_n = 0; end
        end
        if (want != 0) begin
          if (m_cnt == 2) begin m_det = (m_det != 0) ? 0 : 1; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end else m_cnt = 0;
      end
    end
    m_dn = dn_n; m_up = up_n; m_rc = rc_n;
  endtask

  task automatic check(input string tag);
    n_checks++;
    if (detect !== m_det[0] || ref_level !== m_ref[13:0] || delta !== m_delta[14:0]) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual det=%0d ref=%0d delta=%0d expected det=%0d ref=%0d delta=%0d",
               tag, cyc, detect, ref_level, delta, m_det, m_ref, m_delta);
    end
  endtask

  // Drive on the falling edge, model at the rising edge, compare at the next falling edge
  task automatic step(input logic v, input int s, input logic tk, input string tag,
                      input bit chk = 1'b1);
    smp_valid = v; smp_data = s[13:0]; tick_ms = tk;
    @(posedge clk);
    model_step(v, s, tk);
    @(negedge clk);
    if (chk) check(tag);
  endtask

  task automatic repeat_step(input int n, input logic v, input int s, input logic tk,
                             input string tag);
    for (int i = 0; i < n; i++) step(v, s, tk, tag, (i == n - 1) || (i % 97 == 0));
  endtask

  initial begin : watchdog
    while (cyc < WATCHDOG && !done) @(negedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int base;
    void'($urandom(32'd5150));
    model_reset();
    @(negedge clk); @(negedge clk); @(negedge clk);
    n_checks++;
    if (detect !== 1'b0 || ref_level !== '0 || delta !== '0) begin
      n_fail++;
      $display("FAIL R1 reset state actual det=%0d ref=%0d delta=%0d expected 0 0 0",
               detect, ref_level, delta);
    end
    rst = 1'b0;

    // R10 before any sample: nothing loads
    step(1'b0, 4321, 1'b1, "R10 idle before first sample");
    // R1 first sample loads the reference
    step(1'b1, 1000, 1'b0, "R1 first sample load");
    // R2 delta both signs
    step(1'b1, 997, 1'b0, "R2 negative delta");
    step(1'b1, 1004, 1'b0, "R2 positive delta");

    // R3 threshold 6: delta 5 never detects
    thr_sel = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, 1005, 1'b0, "R3 below threshold 6");
    // R4 interrupted run, then three in a row
    step(1'b1, 1006, 1'b0, "R4 run 1");
    step(1'b1, 1006, 1'b0, "R4 run 2");
    step(1'b1, 1002, 1'b0, "R4 disagree resets run");
    step(1'b1, 1006, 1'b0, "R4 run 1 again");
    step(1'b1, 1006, 1'b0, "R4 run 2 again");
    step(1'b1, 1006, 1'b0, "R4 third agreeing sample detects");
    // R10 idle while detecting
    step(1'b0, 0, 1'b0, "R10 idle hold");
    thr_sel = 1'b1;
    step(1'b0, 9999, 1'b1, "R10 idle with option change");
    thr_sel = 1'b0;
    // R5 release for threshold 6 is below 5
    for (int i = 0; i < 3; i++) step(1'b1, 1005, 1'b0, "R5 delta 5 holds detect");
    step(1'b1, 1004, 1'b0, "R5 release run 1");
    step(1'b1, 1004, 1'b0, "R5 release run 2");
    step(1'b1, 1004, 1'b0, "R5 release on third");

    // R3/R5 with threshold 12
    thr_sel = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 1011, 1'b0, "R3 below threshold 12");
    for (int i = 0; i < 3; i++) step(1'b1, 1012, 1'b0, "R3 at threshold 12");
    for (int i = 0; i < 3; i++) step(1'b1, 1010, 1'b0, "R5 delta 10 holds");
    for (int i = 0; i < 3; i++) step(1'b1, 1009, 1'b0, "R5 delta 9 releases");

    // R6 downward drift, tick every cycle
    repeat_step(99, 1'b0, 0, 1'b1, "R6 ticks");
    step(1'b1, 995, 1'b1, "R6 no step before 100 ticks");
    step(1'b1, 995, 1'b1, "R6 first step at 100 ticks");
    repeat_step(250, 1'b1, 995, 1'b1, "R6 repeated steps");

    // R7 upward drift
    repeat_step(2100, 1'b1, 1000, 1'b1, "R7 slow upward drift");

    // R8 frozen while detecting, timers restart on release
    thr_sel = 1'b0; recal_sel = 2'b10;
    base = m_ref;
    repeat_step(600, 1'b1, base + 20, 1'b1, "R8 frozen during detect");
    for (int i = 0; i < 3; i++) step(1'b1, base - 3, 1'b1, "R8 release");
    repeat_step(98, 1'b1, base - 3, 1'b1, "R8 no step right after release");
    repeat_step(5, 1'b1, base - 3, 1'b1, "R8 step after restart");

    // R9 limit 10000 ticks
    recal_sel = 2'b00;
    base = m_ref;
    for (int i = 0; i < 3; i++) step(1'b1, base + 30, 1'b0, "R9 detect 10s");
    repeat_step(9999, 1'b0, 0, 1'b1, "R9 ticking");
    step(1'b1, base + 30, 1'b0, "R9 one tick short still detects");
    step(1'b1, base + 30, 1'b1, "R9 reaches limit");
    step(1'b1, base + 31, 1'b0, "R9 recalibrates at 10s");
    // R9 limit 60000 ticks
    recal_sel = 2'b01;
    for (int i = 0; i < 3; i++) step(1'b1, base + 45, 1'b0, "R9 detect 60s");
    repeat_step(10100, 1'b1, base + 45, 1'b1, "R9 60s outlasts 10s");
    repeat_step(49950, 1'b0, 0, 1'b1, "R9 ticking 60s");
    step(1'b1, base + 45, 1'b0, "R9 recalibrates at 60s");
    // R9 limit disabled
    recal_sel = 2'b11;
    for (int i = 0; i < 3; i++) step(1'b1, base + 60, 1'b0, "R9 detect no limit");
    repeat_step(12000, 1'b0, 0, 1'b1, "R9 ticking no limit");
    step(1'b1, base + 60, 1'b0, "R9 still detecting with no limit");

    // Mixed random stimulus around the reference
    recal_sel = 2'b00;
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 31) - 15;
      if ((i % 500) == 0) thr_sel = $urandom % 2;
      step(($urandom % 4) != 0, m_ref + r, ($urandom % 3) == 0, "R2 R4 random");
    end

    // R1 reset mid-run and reload
    rst = 1'b1; step(1'b0, 0, 1'b0, "R1", 1'b0); model_reset();
    rst = 1'b0;
    check("R1 reset clears outputs");
    step(1'b1, 200, 1'b0, "R1 reload after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule